// File: doc/BRIEF.md
# Second-Order Digital Sigma-Delta Modulator

This block turns a signed multi-bit sample stream into a one-bit stream whose density of ones tracks the input level. It runs at the oversampled rate. A clock enable marks the cycles on which it takes a sample. Two accumulating integrator stages shape the quantization error towards high frequencies. A sign quantizer makes the bit decision, and that bit is fed back to both integrators as a full-scale positive or negative reference. A decimating low-pass filter downstream recovers a multi-bit word from the stream.

Both integrators scale the difference between their input and the reference by one half, using an arithmetic right shift. This keeps the internal swing inside the integrator range. The first stage uses the sample presented on the current enabled cycle. The second stage works from the first stage's registered value, so it sees the first stage one sample late. Both accumulators clamp at the limits of their signed width instead of wrapping around.

Top module: `sdm_mod2`

## Requirements
- R1: While `rst` is high at a clock edge, both integrators are cleared to zero and `bit_out` is forced to 0. This holds whatever the values of `ce` and `din`.
- R2: On a clock edge where `ce` is low, neither integrator changes and `bit_out` keeps its value, whatever `din` carries.
- R3: The feedback reference is +2^(IN_W-1) when the current `bit_out` is 1 and -2^(IN_W-1) when it is 0. It is applied with the same polarity to both stages.
- R4: On an enabled edge, the first integrator adds floor((din - ref) / 2). Here `din` is the sample present at that same edge, so this stage has no delay.
- R5: On an enabled edge, the second integrator adds floor((a1 - ref) / 2). Here a1 is the first integrator's value from before that edge, which gives this stage a one-sample delay.
- R6: On an enabled edge, `bit_out` is loaded with 1 when the second integrator's new value is zero or positive, and with 0 when it is negative. From reset with `din` = -32768, the output after the first four enabled edges is 1, 1, 0, 0. The second of these lands exactly on zero.
- R7: Each integrator clamps to [-2^(INT_W-1), 2^(INT_W-1)-1] when its sum leaves that range. It never wraps.
- R8: With a constant input of +32767, the ones count over 256 settled enabled cycles is at least 248. With 0 it is within 128 ± 8. With -32768 it is at most 8.
- R9: With a constant input between the extremes, the ones density settles to (din + 2^(IN_W-1)) / 2^IN_W. For +16384 that is 192 ± 8 ones in 256 cycles, and for -16384 it is 64 ± 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Sample enable; state advances only when high |
| din | input | IN_W | Signed two's-complement input sample |
| bit_out | output | 1 | Registered one-bit modulator output |

## Verification
The bench builds two copies side by side with the same stimulus. One uses the default 20-bit integrators. The other uses 17-bit integrators, which is the narrowest width that still holds a halved full-scale difference. With the narrow copy, a full-scale negative input drives the second integrator into its negative clamp within six enabled cycles. The wide copy reaches the same clamp only after about thirty, so both copies exercise the limits against the model. Every cycle both outputs are compared with a behavioural integer model. Separate window counts check the ones density at five constant levels.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

  // Polarity of the one-bit feedback reference
  typedef enum logic {
    FB_NEG = 1'b0,
    FB_POS = 1'b1
  } fb_sel_e;

  // Gain of one half: arithmetic shift right by one (rounds toward minus infinity)
  function automatic int half_down(int v);
    return v >>> 1;
  endfunction

  // Clamp a wide sum into a signed range
  function automatic int clamp_int(int v, int lo, int hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/sdm_integrator.sv
module sdm_integrator
  import sdm_pkg::*;
#(
  parameter int X_W   = 16,
  parameter int ACC_W = 20
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ce,
  input  logic signed [X_W-1:0]   x,
  input  logic signed [ACC_W-1:0] ref_val,
  output logic signed [ACC_W-1:0] acc_q,
  output logic signed [ACC_W-1:0] acc_next,
  output logic                    sat_hi,
  output logic                    sat_lo
);

  localparam int ACC_MAX = (2 ** (ACC_W - 1)) - 1;
  localparam int ACC_MIN = -(2 ** (ACC_W - 1));

  int diff_w;
  int step_w;
  int sum_w;

  always_comb begin
    diff_w = int'(x) - int'(ref_val);
    step_w = half_down(diff_w);
    sum_w  = int'(acc_q) + step_w;
  end

  assign sat_hi   = (sum_w > ACC_MAX);
  assign sat_lo   = (sum_w < ACC_MIN);
  assign acc_next = ACC_W'(clamp_int(sum_w, ACC_MIN, ACC_MAX));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (ce) begin
      acc_q <= acc_next;
    end
  end

endmodule

// File: rtl/sdm_fb_dac.sv
module sdm_fb_dac
  import sdm_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int ACC_W = 20
) (
  input  logic                    bit_q,
  output logic signed [ACC_W-1:0] ref_val
);

  localparam int REF_MAG = 2 ** (IN_W - 1);

  fb_sel_e sel;

  assign sel = fb_sel_e'(bit_q);

  always_comb begin
    case (sel)
      FB_POS:  ref_val = ACC_W'(REF_MAG);
      default: ref_val = ACC_W'(-REF_MAG);
    endcase
  end

endmodule

// File: rtl/sdm_quantizer.sv
module sdm_quantizer #(
  parameter int ACC_W = 20
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ce,
  input  logic signed [ACC_W-1:0] acc_in,
  output logic                    decide_w,
  output logic                    bit_q
);

  // Zero counts as non-negative
  assign decide_w = ~acc_in[ACC_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q <= 1'b0;
    end else if (ce) begin
      bit_q <= decide_w;
    end
  end

endmodule

// File: rtl/sdm_mod2.sv
module sdm_mod2 #(
  parameter int IN_W  = 16,
  parameter int INT_W = 20
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ce,
  input  logic signed [IN_W-1:0] din,
  output logic                   bit_out
);

  logic signed [INT_W-1:0] fb_val;
  logic signed [INT_W-1:0] i1_q;
  logic signed [INT_W-1:0] i1_next;
  logic                    i1_hi;
  logic                    i1_lo;
  logic signed [INT_W-1:0] i2_q;
  logic signed [INT_W-1:0] i2_next;
  logic                    i2_hi;
  logic                    i2_lo;
  logic                    q_decide;

  sdm_fb_dac #(
    .IN_W (IN_W),
    .ACC_W(INT_W)
  ) u_dac (
    .bit_q  (bit_out),
    .ref_val(fb_val)
  );

  // Stage one: takes the live sample
  sdm_integrator #(
    .X_W  (IN_W),
    .ACC_W(INT_W)
  ) u_int1 (
    .clk     (clk),
    .rst     (rst),
    .ce      (ce),
    .x       (din),
    .ref_val (fb_val),
    .acc_q   (i1_q),
    .acc_next(i1_next),
    .sat_hi  (i1_hi),
    .sat_lo  (i1_lo)
  );

  // Stage two: takes stage one's registered value (one-sample delay)
  sdm_integrator #(
    .X_W  (INT_W),
    .ACC_W(INT_W)
  ) u_int2 (
    .clk     (clk),
    .rst     (rst),
    .ce      (ce),
    .x       (i1_q),
    .ref_val (fb_val),
    .acc_q   (i2_q),
    .acc_next(i2_next),
    .sat_hi  (i2_hi),
    .sat_lo  (i2_lo)
  );

  sdm_quantizer #(
    .ACC_W(INT_W)
  ) u_quant (
    .clk     (clk),
    .rst     (rst),
    .ce      (ce),
    .acc_in  (i2_next),
    .decide_w(q_decide),
    .bit_q   (bit_out)
  );

endmodule

// File: rtl/sdm_mod2_chk.sv
module sdm_mod2_chk #(
  parameter int IN_W  = 16,
  parameter int INT_W = 20
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    ce,
  input logic signed [IN_W-1:0]  din,
  input logic                    bit_out,
  input logic signed [INT_W-1:0] i1_q,
  input logic signed [INT_W-1:0] i2_q,
  input logic                    i1_hi,
  input logic                    i1_lo,
  input logic                    i2_hi,
  input logic                    i2_lo
);

  localparam int REF_MAG = 2 ** (IN_W - 1);
  localparam int LIM_HI  = (2 ** (INT_W - 1)) - 1;
  localparam int LIM_LO  = -(2 ** (INT_W - 1));

  function automatic int floor_half(int v);
    return (v - (v & 1)) / 2;
  endfunction

  int fb_c;
  int exp1;
  int exp2;

  always_comb begin
    fb_c = bit_out ? REF_MAG : -REF_MAG;
    exp1 = int'(i1_q) + floor_half(int'(din) - fb_c);
    exp2 = int'(i2_q) + floor_half(int'(i1_q) - fb_c);
  end

  logic rst_seen = 1'b0;
  always @(posedge clk) rst_seen <= rst;

  always @(negedge clk) begin
    if (rst_seen) begin
      p_reset_clear_r1: assert (bit_out == 1'b0 && i1_q == '0 && i2_q == '0);
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(bit_out) && $stable(i1_q) && $stable(i2_q)));

  p_int1_step_r4: assert property (@(posedge clk) disable iff (rst)
    (ce && !i1_hi && !i1_lo) |=> (int'(i1_q) == $past(exp1)));

  p_int2_step_r5: assert property (@(posedge clk) disable iff (rst)
    (ce && !i2_hi && !i2_lo) |=> (int'(i2_q) == $past(exp2)));

  p_quant_sign_r6: assert property (@(posedge clk) disable iff (rst)
    ce |=> (bit_out == (int'(i2_q) >= 0)));

  p_sat_i1_hi_r7: assert property (@(posedge clk) disable iff (rst)
    (ce && i1_hi) |=> (int'(i1_q) == LIM_HI));

  p_sat_i1_lo_r7: assert property (@(posedge clk) disable iff (rst)
    (ce && i1_lo) |=> (int'(i1_q) == LIM_LO));

  p_sat_i2_hi_r7: assert property (@(posedge clk) disable iff (rst)
    (ce && i2_hi) |=> (int'(i2_q) == LIM_HI));

  p_sat_i2_lo_r7: assert property (@(posedge clk) disable iff (rst)
    (ce && i2_lo) |=> (int'(i2_q) == LIM_LO));

endmodule

bind sdm_mod2 sdm_mod2_chk #(
  .IN_W (IN_W),
  .INT_W(INT_W)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .ce     (ce),
  .din    (din),
  .bit_out(bit_out),
  .i1_q   (i1_q),
  .i2_q   (i2_q),
  .i1_hi  (i1_hi),
  .i1_lo  (i1_lo),
  .i2_hi  (i2_hi),
  .i2_lo  (i2_lo)
);

// File: tb/test_sdm_mod2.sv
module test_sdm_mod2;

  localparam int CLK_PERIOD = 10;
  localparam int IN_W       = 16;
  localparam int WIDE_W     = 20;
  localparam int NARROW_W   = 17;
  localparam int REF_MAG    = 2 ** (IN_W - 1);

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   ce  = 1'b0;
  logic signed [IN_W-1:0] din = '0;
  logic                   bout_w;
  logic                   bout_n;

  int n_chk  = 0;
  int n_fail = 0;
  logic cmp_en = 1'b0;
  logic done   = 1'b0;
  string cur_req = "R1";

  always #(CLK_PERIOD / 2) clk = ~clk;

  sdm_mod2 #(.IN_W(IN_W), .INT_W(WIDE_W)) i_sdm_mod2 (
    .clk(clk), .rst(rst), .ce(ce), .din(din), .bit_out(bout_w)
  );

  sdm_mod2 #(.IN_W(IN_W), .INT_W(NARROW_W)) i_sdm_mod2_narrow (
    .clk(clk), .rst(rst), .ce(ce), .din(din), .bit_out(bout_n)
  );

  // ---------------- reference model ----------------
  int m_i1 [2];
  int m_i2 [2];
  int m_y  [2];
  int m_hi [2];
  int m_lo [2];

  function automatic int div2_floor(int v);
    if (v >= 0) return v / 2;
    return -((1 - v) / 2);
  endfunction

  function automatic int limit(int v, int k);
    if (v > m_hi[k]) return m_hi[k];
    if (v < m_lo[k]) return m_lo[k];
    return v;
  endfunction

  initial begin
    m_hi[0] = (2 ** (WIDE_W - 1)) - 1;
    m_lo[0] = -(2 ** (WIDE_W - 1));
    m_hi[1] = (2 ** (NARROW_W - 1)) - 1;
    m_lo[1] = -(2 ** (NARROW_W - 1));
    for (int k = 0; k < 2; k++) begin
      m_i1[k] = 0; m_i2[k] = 0; m_y[k] = 0;
    end
  end

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (rst) begin
        m_i1[k] = 0; m_i2[k] = 0; m_y[k] = 0;
      end else if (ce) begin
        int fb, n1, n2;
        fb = (m_y[k] != 0) ? REF_MAG : -REF_MAG;           // R3
        n1 = limit(m_i1[k] + div2_floor(int'(din) - fb), k); // R4, R7
        n2 = limit(m_i2[k] + div2_floor(m_i1[k] - fb), k);   // R5, R7
        m_i1[k] = n1;
        m_i2[k] = n2;
        m_y[k]  = (n2 >= 0) ? 1 : 0;                         // R6
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_range(string req, int act, int lo, int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  // per-cycle comparison against the model, both widths
  always @(negedge clk) begin
    if (cmp_en) begin
      chk(cur_req, int'(bout_w), m_y[0]);
      chk(cur_req, int'(bout_n), m_y[1]);
    end
  end

  task automatic do_reset();
    rst = 1'b1; ce = 1'b1; din = 16'sd32767;
    repeat (2) @(negedge clk);
    chk("R1", int'(bout_w), 0);
    chk("R1", int'(bout_n), 0);
    rst = 1'b0;
  endtask

  task automatic density(string req, logic signed [IN_W-1:0] lvl, int lo, int hi);
    int ones;
    do_reset();
    cur_req = req;
    ce = 1'b1; din = lvl;
    repeat (64) @(negedge clk);
    ones = 0;
    for (int c = 0; c < 256; c++) begin
      @(negedge clk);
      ones += int'(bout_w);
    end
    chk_range(req, ones, lo, hi);
  endtask

  // watchdog
  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int hold_w, hold_n;
    logic [15:0] lfsr;
    int tri_v, tri_d;

    // R1: reset dominates ce and din
    repeat (3) @(negedge clk);
    cur_req = "R1";
    rst = 1'b1; ce = 1'b1; din = 16'sd32767;
    @(negedge clk);
    chk("R1", int'(bout_w), 0);
    chk("R1", int'(bout_n), 0);
    cmp_en = 1'b1;

    // R6: sequence from reset with full-scale negative input
    cur_req = "R6";
    rst = 1'b0; ce = 1'b1; din = -16'sd32768;
    @(negedge clk); chk("R6", int'(bout_w), 1);
    @(negedge clk); chk("R6", int'(bout_w), 1);  // quantizer input exactly zero
    @(negedge clk); chk("R6", int'(bout_w), 0);
    @(negedge clk); chk("R6", int'(bout_w), 0);
    chk("R6", int'(bout_n), 0);

    // R7: keep pushing both widths into the negative clamp
    cur_req = "R7";
    repeat (40) @(negedge clk);
    din = 16'sd32767;
    repeat (60) @(negedge clk);

    // R2: enable low, input churning, output and state must hold
    cur_req = "R2";
    hold_w = int'(bout_w);
    hold_n = int'(bout_n);
    ce = 1'b0;
    for (int c = 0; c < 20; c++) begin
      din = 16'(c * 7919 + 123);
      @(negedge clk);
      chk("R2", int'(bout_w), hold_w);
      chk("R2", int'(bout_n), hold_n);
    end
    ce = 1'b1; din = 16'sd1000;
    repeat (50) @(negedge clk);   // model match shows integrators were held

    // R8 and R9: density at constant levels
    density("R8", 16'sd32767, 248, 256);
    density("R8", 16'sd0, 120, 136);
    density("R8", -16'sd32768, 0, 8);
    density("R9", 16'sd16384, 184, 200);
    density("R9", -16'sd16384, 56, 72);

    // R3 R4 R5: triangle input with irregular enable
    do_reset();
    cur_req = "R3 R4 R5";
    lfsr = 16'hACE1;
    tri_v = 0; tri_d = 97;
    for (int c = 0; c < 3000; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ce = lfsr[0] | lfsr[3];
      tri_v += tri_d;
      if (tri_v > 30000 || tri_v < -30000) tri_d = -tri_d;
      din = 16'(tri_v);
      @(negedge clk);
    end

    cmp_en = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule